// File: doc/BRIEF.md
# Sampling Converter Control and Parallel Read Port

This block is the digital sequencer for the converter side of a 16-bit parallel-output sampling converter. A host drives two active-level controls: `read_mode` (high selects reading, low arms a conversion) and the active-low chip select `select_n`. A conversion begins when chip select falls while `read_mode` is low. The block then drops `ready` and raises `converting`, and it times the conversion with a cycle counter. Partway through it takes a hold sample from `core_word`, which stands in for the analog core. Near the end it publishes the result in a holding register.

The data word is always driven on `dout`. Whether the bus counts as driven is shown only by `dout_en`, which stands for the pad tri-state. During a conversion the bus is quiet until a short window before `ready` rises. The window is suppressed if chip select was seen high at any point in that conversion. Outside a conversion the bus follows the read decode. If both controls are still low a fixed number of cycles after `ready` rises, another conversion starts by itself. All timing figures are parameters counted in clock cycles.

Top module: `adc_bus_ctrl`

## Requirements
- R1: At the first clock edge that samples `select_n` low after it was sampled high, with `read_mode` low and no conversion running, `ready` goes to 0 and `converting` to 1.
- R2: Once started, `ready` stays 0 for exactly CONV_CYC cycles and then returns to 1, and `converting` returns to 0 at the same time.
- R3: `core_word` is captured at the edge APER_CYC cycles after the start edge. That captured value appears on `dout` LEAD_CYC cycles before `ready` rises, and `dout` holds it until the next conversion publishes a new one.
- R4: While converting, `dout_en` is 0 except during the last LEAD_CYC cycles. In those cycles it is 1 only if `select_n` was sampled low on every edge since the start.
- R5: When no conversion is running, `dout_en` is 1 in the cycle after an edge that samples `read_mode` = 1 and `select_n` = 0, and 0 after any other sample. This lets a result whose window was suppressed be read later.
- R6: A chip-select fall during a conversion does not start or extend anything. A fall of `read_mode` while `select_n` is already low does not start a conversion.
- R7: If the edge REARM_CYC cycles after `ready` rises samples both `read_mode` and `select_n` low, a new conversion starts at that edge. If either is high there, the block returns to acquire. A chip-select fall with `read_mode` low before that edge starts a conversion at once.
- R8: After synchronous reset, `ready` = 1, `converting` = 0, `dout_en` = 0 and `dout` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| read_mode | input | 1 | 1 = read, 0 = arm conversion |
| select_n | input | 1 | Active-low chip select |
| core_word | input | DATA_W | Stand-in for the analog core's digitised value |
| dout | output | DATA_W | Result register contents |
| dout_en | output | 1 | Bus drive enable (0 stands for high impedance) |
| ready | output | 1 | Low while a conversion runs |
| converting | output | 1 | Mode: 0 acquire, 1 convert |

## Verification
The bench changes `core_word` on every cycle. A capture taken one edge early or late therefore shows up as a wrong word on `dout`. It raises chip select partway through a conversion and then reads back afterwards. A block that ignores the suppression would drive the bus in the end window, and one that discards the result would return a stale word. It leaves both controls low past the end of a conversion and checks for an automatic restart exactly REARM_CYC cycles later. It also checks that raising chip select inside that window prevents the restart. Chip-select falls in the middle of a conversion, and a `read_mode` fall while chip select is low, must leave the `ready` pulse width unchanged. A design that restarted or stretched the conversion would show a different pulse width.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  typedef enum logic [1:0] {
    PH_ACQ   = 2'd0,
    PH_CONV  = 2'd1,
    PH_REARM = 2'd2
  } phase_t;
endpackage

// File: rtl/adc_start_detect.sv
module adc_start_detect (
  input  logic clk,
  input  logic rst,
  input  logic read_mode,
  input  logic select_n,
  output logic start_req,
  output logic both_low
);
  logic sel_q;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b1;
    else     sel_q <= select_n;
  end

  assign start_req = sel_q & ~select_n & ~read_mode;
  assign both_low  = ~read_mode & ~select_n;
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_ctrl_pkg::*;
#(
  parameter int CONV_CYC  = 413,
  parameter int APER_CYC  = 5,
  parameter int LEAD_CYC  = 4,
  parameter int REARM_CYC = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic both_low,
  output logic in_conv,
  output logic in_win,
  output logic conv_nxt,
  output logic win_nxt,
  output logic start_now,
  output logic sample_stb,
  output logic load_stb
);
  localparam int MAXC  = (CONV_CYC > REARM_CYC) ? CONV_CYC : REARM_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] CONV_LAST  = CNT_W'(CONV_CYC - 1);
  localparam logic [CNT_W-1:0] REARM_LAST = CNT_W'(REARM_CYC - 1);
  localparam logic [CNT_W-1:0] APER_AT    = CNT_W'(APER_CYC - 1);
  localparam logic [CNT_W-1:0] LOAD_AT    = CNT_W'(CONV_CYC - LEAD_CYC - 1);
  localparam logic [CNT_W-1:0] WIN_LO     = CNT_W'(CONV_CYC - LEAD_CYC);

  phase_t           phase_q, phase_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_q + 1'b1;
    case (phase_q)
      PH_ACQ: begin
        cnt_n = '0;
        if (start_req) phase_n = PH_CONV;
      end
      PH_CONV: begin
        if (cnt_q == CONV_LAST) begin
          phase_n = PH_REARM;
          cnt_n   = '0;
        end
      end
      PH_REARM: begin
        if (start_req || (cnt_q == REARM_LAST && both_low)) begin
          phase_n = PH_CONV;
          cnt_n   = '0;
        end else if (cnt_q == REARM_LAST) begin
          phase_n = PH_ACQ;
          cnt_n   = '0;
        end
      end
      default: begin
        phase_n = PH_ACQ;
        cnt_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_ACQ;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
    end
  end

  assign in_conv    = (phase_q == PH_CONV);
  assign in_win     = in_conv && (cnt_q >= WIN_LO);
  assign conv_nxt   = (phase_n == PH_CONV);
  assign win_nxt    = conv_nxt && (cnt_n >= WIN_LO);
  assign start_now  = conv_nxt && !in_conv;
  assign sample_stb = in_conv && (cnt_q == APER_AT);
  assign load_stb   = in_conv && (cnt_q == LOAD_AT);

  // R1: an accepted start request enters the convert phase
  p_start_r1: assert property (@(posedge clk) disable iff (rst)
    (start_req && phase_q != PH_CONV) |=> (phase_q == PH_CONV));

  // R6: inside a conversion the count only advances; nothing restarts it
  p_no_retrigger_r6: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_CONV && cnt_q != CONV_LAST) |=>
      (phase_q == PH_CONV && cnt_q == $past(cnt_q) + 1'b1));

  // R7: both controls low at the end of the re-arm window restarts
  p_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_REARM && cnt_q == REARM_LAST && both_low) |=>
      (phase_q == PH_CONV && cnt_q == '0));
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_stb,
  input  logic              load_stb,
  input  logic [DATA_W-1:0] core_word,
  output logic [DATA_W-1:0] result_q
);
  logic [DATA_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q   <= '0;
      result_q <= '0;
    end else begin
      if (sample_stb) held_q   <= core_word;
      if (load_stb)   result_q <= held_q;
    end
  end

  // R3: the published word changes only on a publish strobe
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !load_stb |=> $stable(result_q));
endmodule

// File: rtl/adc_bus_gate.sv
module adc_bus_gate (
  input  logic clk,
  input  logic rst,
  input  logic read_mode,
  input  logic select_n,
  input  logic start_now,
  input  logic in_conv,
  input  logic in_win,
  input  logic conv_nxt,
  input  logic win_nxt,
  output logic dout_en
);
  logic mask_q, mask_nxt, en_d;

  always_comb begin
    mask_nxt = start_now ? 1'b0 : (mask_q | (in_conv & select_n));
    en_d     = conv_nxt ? (win_nxt & ~mask_nxt) : (read_mode & ~select_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= 1'b0;
      dout_en <= 1'b0;
    end else begin
      mask_q  <= mask_nxt;
      dout_en <= en_d;
    end
  end

  // R4: bus stays quiet before the end window of a conversion
  p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (in_conv && !in_win) |-> !dout_en);

  // R4: a conversion that saw chip select high never drives the bus
  p_mask_r4: assert property (@(posedge clk) disable iff (rst)
    (in_conv && mask_q) |-> !dout_en);
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl #(
  parameter int DATA_W    = 16,
  parameter int CONV_CYC  = 413,
  parameter int APER_CYC  = 5,
  parameter int LEAD_CYC  = 4,
  parameter int REARM_CYC = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              read_mode,
  input  logic              select_n,
  input  logic [DATA_W-1:0] core_word,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              ready,
  output logic              converting
);
  logic start_req, both_low;
  logic in_conv, in_win, conv_nxt, win_nxt, start_now, sample_stb, load_stb;

  initial begin
    p_params_ok: assert (APER_CYC >= 1 && LEAD_CYC >= 1 && REARM_CYC >= 1 &&
                         APER_CYC < CONV_CYC - LEAD_CYC);
  end

  adc_start_detect u_start (
    .clk(clk), .rst(rst), .read_mode(read_mode), .select_n(select_n),
    .start_req(start_req), .both_low(both_low)
  );

  adc_conv_seq #(
    .CONV_CYC(CONV_CYC), .APER_CYC(APER_CYC),
    .LEAD_CYC(LEAD_CYC), .REARM_CYC(REARM_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .start_req(start_req), .both_low(both_low),
    .in_conv(in_conv), .in_win(in_win), .conv_nxt(conv_nxt),
    .win_nxt(win_nxt), .start_now(start_now),
    .sample_stb(sample_stb), .load_stb(load_stb)
  );

  adc_result_reg #(.DATA_W(DATA_W)) u_result (
    .clk(clk), .rst(rst), .sample_stb(sample_stb), .load_stb(load_stb),
    .core_word(core_word), .result_q(dout)
  );

  adc_bus_gate u_gate (
    .clk(clk), .rst(rst), .read_mode(read_mode), .select_n(select_n),
    .start_now(start_now), .in_conv(in_conv), .in_win(in_win),
    .conv_nxt(conv_nxt), .win_nxt(win_nxt), .dout_en(dout_en)
  );

  assign converting = in_conv;
  assign ready      = ~in_conv;
endmodule

// File: tb/adc_bus_ctrl_bench.sv
`timescale 1ns/1ps
module adc_bus_ctrl_bench;
  localparam int DW    = 16;
  localparam int CONV  = 413;
  localparam int APER  = 5;
  localparam int LEAD  = 4;
  localparam int REARM = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rm  = 1'b1;
  logic s_n = 1'b1;
  logic [DW-1:0] core = 16'hACE1;
  logic [DW-1:0] dout;
  logic dout_en, ready, converting;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  adc_bus_ctrl #(
    .DATA_W(DW), .CONV_CYC(CONV), .APER_CYC(APER),
    .LEAD_CYC(LEAD), .REARM_CYC(REARM)
  ) u_adc_bus_ctrl (
    .clk(clk), .rst(rst), .read_mode(rm), .select_n(s_n), .core_word(core),
    .dout(dout), .dout_en(dout_en), .ready(ready), .converting(converting)
  );

  // behavioural reference: time since start, time since ready rose
  int t_conv = -1;
  int t_rearm = -1;
  bit m_prev_s = 1'b1;
  bit m_mask = 1'b0;
  bit m_en = 1'b0;
  logic [DW-1:0] m_held = '0;
  logic [DW-1:0] m_res = '0;

  always @(posedge clk) begin
    if (rst) begin
      t_conv = -1; t_rearm = -1; m_prev_s = 1'b1; m_mask = 1'b0;
      m_held = '0; m_res = '0; m_en = 1'b0;
    end else begin
      bit sreq;
      sreq = m_prev_s && !s_n && !rm;
      if (t_conv >= 0) begin
        if (t_conv == APER - 1) m_held = core;
        if (t_conv == CONV - LEAD - 1) m_res = m_held;
        if (s_n) m_mask = 1'b1;
        if (t_conv == CONV - 1) begin t_conv = -1; t_rearm = 0; end
        else t_conv++;
      end else if (sreq) begin
        t_conv = 0; t_rearm = -1; m_mask = 1'b0;
      end else if (t_rearm >= 0) begin
        if (t_rearm == REARM - 1) begin
          t_rearm = -1;
          if (!rm && !s_n) begin t_conv = 0; m_mask = 1'b0; end
        end else t_rearm++;
      end
      m_en = (t_conv >= 0) ? (t_conv >= CONV - LEAD && !m_mask) : (rm && !s_n);
      m_prev_s = s_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(ready == (t_conv < 0), "R1 R2 ready", ready, t_conv < 0);
      chk(converting == (t_conv >= 0), "R2 converting", converting, t_conv >= 0);
      chk(dout_en == m_en, "R4 R5 dout_en", dout_en, m_en);
      chk(dout == m_res, "R3 dout", dout, m_res);
    end
  end

  // ready low pulse width
  int low_run = 0;
  always @(negedge clk) begin
    if (rst) low_run = 0;
    else if (!ready) low_run++;
    else if (low_run != 0) begin
      chk(low_run == CONV, "R2 busy width", low_run, CONV);
      low_run = 0;
    end
  end

  // stimulus for core word: new value every cycle
  always @(negedge clk)
    core <= {core[14:0], core[15] ^ core[13] ^ core[12] ^ core[10]};

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic r, input logic s);
    @(negedge clk);
    rm = r; s_n = s;
  endtask

  task automatic wait_ready;
    while (!ready) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  bit saw_en;

  initial begin
    cyc(5);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    chk(ready == 1'b1 && converting == 1'b0 && dout_en == 1'b0 && dout == '0,
        "R8 reset state", {ready, converting, dout_en}, 3'b100);

    // normal conversion, read afterwards while still selected
    drive(1'b0, 1'b1); cyc(12);
    drive(1'b0, 1'b0); cyc(1);
    chk(ready == 1'b0 && converting == 1'b1, "R1 start", ready, 0);
    cyc(3); drive(1'b1, 1'b0);
    wait_ready(); cyc(3);
    chk(dout_en == 1'b1, "R5 read after", dout_en, 1);
    drive(1'b1, 1'b1); cyc(40);

    // chip select raised early: window suppressed, read later
    drive(1'b0, 1'b0); cyc(10);
    drive(1'b1, 1'b1);
    saw_en = 1'b0;
    while (!ready) begin @(negedge clk); if (converting && dout_en) saw_en = 1'b1; end
    chk(!saw_en, "R4 suppressed window", saw_en, 0);
    cyc(50);
    drive(1'b1, 1'b0); cyc(2);
    chk(dout_en == 1'b1, "R5 late read", dout_en, 1);
    drive(1'b1, 1'b1); cyc(40);

    // R6: chip select fall mid-conversion is ignored
    drive(1'b0, 1'b0); cyc(50);
    drive(1'b0, 1'b1); drive(1'b0, 1'b0); cyc(5);
    drive(1'b1, 1'b1);
    wait_ready(); cyc(40);

    // R6: read_mode falling under a low select does not start
    drive(1'b1, 1'b0); cyc(3);
    drive(1'b0, 1'b0); cyc(5);
    chk(ready == 1'b1, "R6 no start on read_mode fall", ready, 1);
    drive(1'b1, 1'b1); cyc(40);

    // R7: both held low past the end restarts
    drive(1'b0, 1'b0);
    cyc(2); wait_ready();
    cyc(REARM + 1);
    chk(converting == 1'b1, "R7 auto restart", converting, 1);
    drive(1'b1, 1'b1);
    wait_ready(); cyc(10);
    drive(1'b0, 1'b1); cyc(REARM + 5);

    // R7: select raised inside the window prevents the restart
    drive(1'b0, 1'b0);
    cyc(2); wait_ready(); cyc(10);
    drive(1'b0, 1'b1); cyc(REARM);
    chk(ready == 1'b1, "R7 no restart", ready, 1);

    // R7: a fresh select fall inside the window starts at once
    drive(1'b0, 1'b0);
    cyc(2); wait_ready(); cyc(5);
    drive(1'b0, 1'b1); drive(1'b0, 1'b0); cyc(1);
    chk(converting == 1'b1, "R7 start in window", converting, 1);
    drive(1'b1, 1'b1);
    wait_ready(); cyc(50);

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule